// File: doc/BRIEF.md
# T1 Superframe Alignment Searcher

This block recovers frame and superframe alignment from a serial T1 line that uses the 12-frame superframe format. One received bit arrives on every rising clock edge. The block keeps its own 193-bit frame counter and watches every bit position at once. It looks for a position that alternates 1,0,1,0 when sampled every second frame. Once exactly one such position is trusted, the block declares terminal-frame lock and flywheels on it. From then on it checks the terminal bits against the expected alternation.

After terminal lock, the framing bits of the interleaved frames are shifted into a six-bit history. When that history shows the signalling sequence 0,0,1,1,1,0, the block declares superframe lock and numbers the frames 1 to 12. Superframe lock is only an extra: terminal lock stays up whether or not the signalling sequence ever appears.

A control input chooses how strictly the search rejects look-alike patterns. In the strict setting, sync is refused while a second position also shows the pattern. In the permissive setting, the first position that qualifies wins. Two errors among four consecutive terminal bits drop both locks and restart the whole search from a clean candidate memory.

Top module: `t1sf_framer`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, term_lock_n and multi_lock_n are 1 and frm_pulse, sf_pulse and sig_pulse are 0.
- R2: A frame is 193 bits. With allow_mimic=1, the first bit position whose samples, taken every second frame, alternate for 8 consecutive samples is accepted. term_lock_n falls in the cycle after that 8th sample.
- R3: With allow_mimic=0, lock is taken only at a position's 9th or later consecutive alternating sample, and only while it is the single qualified position. While two positions qualify, term_lock_n stays 1. Once the competitor breaks its alternation, lock is taken at the next sample of the remaining position.
- R4: While terminal lock holds, frm_pulse is 1 in exactly the cycles in which the locked framing bit is on rx_bit. That is every 193 cycles, starting one frame after the lock sample.
- R5: The signalling search runs only under terminal lock. It looks at the framing bits of the frames between terminal bits. multi_lock_n falls in the cycle after six consecutive such bits read 0,0,1,1,1,0, and it is never 0 while term_lock_n is 1.
- R6: Under superframe lock, the frame whose framing bit completes the sequence is frame 12. sf_pulse marks the framing bit of frame 1, and sig_pulse marks the framing bits of frames 6 and 12. Both are subsets of frm_pulse.
- R7: Terminal lock is kept when the signalling sequence never appears on the interleaved framing bits.
- R8: Two errors within any four consecutive terminal framing bits release both locks in the cycle after the second error, and the search restarts with all candidate history cleared. A single error within four does not release lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial line bit |
| allow_mimic | input | 1 | 1: first qualifying position wins; 0: lock only with a single candidate |
| frm_pulse | output | 1 | High while the framing bit of each frame is on rx_bit |
| sf_pulse | output | 1 | High on the framing bit of superframe frame 1 |
| sig_pulse | output | 1 | High on the framing bits of frames 6 and 12 |
| term_lock_n | output | 1 | Terminal-frame lock status, active low |
| multi_lock_n | output | 1 | Superframe lock status, active low |

## Verification
The hardest state to reach from the ports is two positions qualifying at the same time, followed by the strict setting releasing exactly one of them. The stimulus plants a second alternating position in the same frame phase as the true one, earlier in the frame. Both qualify in the same sweep. The planted position is then frozen so that it breaks, and the bench expects lock on the true position during that same sweep. The same stream, run with the permissive setting, must lock on the planted position instead. The release path is reached by flipping one terminal bit, then two more within four, and then following the fresh search to relock.

// File: rtl/t1sf_pkg.sv
package t1sf_pkg;
    localparam int SF_FRAMES = 12;
    localparam int SIG_LEN   = 6;
    // signalling sequence on interleaved framing bits, oldest in the MSB
    localparam logic [SIG_LEN-1:0] SIG_WORD = 6'b001110;
endpackage

// File: rtl/t1sf_bitpos.sv
module t1sf_bitpos #(
    parameter int FRAME_BITS = 193,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos_o,
    output logic             odd_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             odd;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.pos == LAST) begin
            cnt_d.pos = '0;
            cnt_d.odd = !cnt_q.odd;
        end else begin
            cnt_d.pos = cnt_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pos_o = cnt_q.pos;
    assign odd_o = cnt_q.odd;
endmodule

// File: rtl/t1sf_cands.sv
module t1sf_cands #(
    parameter int FRAME_BITS = 193,
    parameter int QUAL_LEN   = 8,
    localparam int POS_W   = $clog2(FRAME_BITS),
    localparam int RUN_TOP = QUAL_LEN + 1,
    localparam int RUN_W   = $clog2(RUN_TOP + 1),
    localparam int CNT_W   = $clog2(2 * FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             odd_i,
    input  logic             bit_i,
    output logic [RUN_W-1:0] run_o,
    output logic             solo_o
);
    localparam logic [RUN_W-1:0] QUAL_V = RUN_W'(QUAL_LEN);
    localparam logic [RUN_W-1:0] TOP_V  = RUN_W'(RUN_TOP);

    // one alternation history per (frame phase, bit position) slot
    logic             last_q [2][FRAME_BITS];
    logic [RUN_W-1:0] run_q  [2][FRAME_BITS];
    logic [CNT_W-1:0] nqual_q, nqual_d;

    logic [RUN_W-1:0] old_run, new_run;
    logic             old_bit, was_ok, now_ok;

    always_comb begin
        old_run = run_q[odd_i][pos_i];
        old_bit = last_q[odd_i][pos_i];
        if (old_run != '0 && bit_i != old_bit)
            new_run = (old_run == TOP_V) ? TOP_V : old_run + RUN_W'(1);
        else
            new_run = RUN_W'(1);
        was_ok  = (old_run >= QUAL_V);
        now_ok  = (new_run >= QUAL_V);
        nqual_d = nqual_q + CNT_W'(now_ok) - CNT_W'(was_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nqual_q <= '0;
            for (int p = 0; p < FRAME_BITS; p++) begin
                for (int h = 0; h < 2; h++) begin
                    last_q[h][p] <= 1'b0;
                    run_q[h][p]  <= '0;
                end
            end
        end else if (clear_i) begin
            nqual_q <= '0;
            for (int p = 0; p < FRAME_BITS; p++) begin
                for (int h = 0; h < 2; h++) begin
                    last_q[h][p] <= 1'b0;
                    run_q[h][p]  <= '0;
                end
            end
        end else if (en_i) begin
            last_q[odd_i][pos_i] <= bit_i;
            run_q[odd_i][pos_i]  <= new_run;
            nqual_q              <= nqual_d;
        end
    end

    assign run_o  = new_run;
    assign solo_o = (nqual_d == CNT_W'(1));
endmodule

// File: rtl/t1sf_framer.sv
module t1sf_framer #(
    parameter int FRAME_BITS = 193,
    parameter int QUAL_LEN   = 8,
    parameter int LOSS_WIN   = 4,
    parameter int LOSS_ERRS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic allow_mimic,
    output logic frm_pulse,
    output logic sf_pulse,
    output logic sig_pulse,
    output logic term_lock_n,
    output logic multi_lock_n
);
    import t1sf_pkg::*;

    localparam int POS_W   = $clog2(FRAME_BITS);
    localparam int RUN_TOP = QUAL_LEN + 1;
    localparam int RUN_W   = $clog2(RUN_TOP + 1);
    localparam logic [RUN_W-1:0] QUAL_V  = RUN_W'(QUAL_LEN);
    localparam logic [RUN_W-1:0] TOP_V   = RUN_W'(RUN_TOP);
    localparam logic [3:0]       SF_LAST = 4'(SF_FRAMES - 1);
    localparam logic [3:0]       SF_SIX  = 4'(SF_FRAMES / 2 - 1);

    typedef struct packed {
        logic               tlock;
        logic               mlock;
        logic [POS_W-1:0]   fpos;
        logic               ft_next;
        logic               last_ft;
        logic [LOSS_WIN-1:0] errs;
        logic [SIG_LEN-1:0] sig_hist;
        logic [3:0]         sf_idx;
    } st_t;

    st_t st_d, st_q;

    logic [POS_W-1:0] pos;
    logic             odd;
    logic [RUN_W-1:0] run;
    logic             solo, clr, search_en;
    logic             at_fbit, ft_err, sig_hit, accept;
    logic [LOSS_WIN-1:0] err_win;
    logic [SIG_LEN-1:0]  sig_next;

    t1sf_bitpos #(.FRAME_BITS(FRAME_BITS)) u_pos (
        .clk(clk), .rst_n(rst_n), .pos_o(pos), .odd_o(odd)
    );

    assign search_en = !st_q.tlock;

    t1sf_cands #(.FRAME_BITS(FRAME_BITS), .QUAL_LEN(QUAL_LEN)) u_cands (
        .clk(clk), .rst_n(rst_n), .clear_i(clr), .en_i(search_en),
        .pos_i(pos), .odd_i(odd), .bit_i(rx_bit),
        .run_o(run), .solo_o(solo)
    );

    always_comb begin
        st_d     = st_q;
        clr      = 1'b0;
        at_fbit  = st_q.tlock && (pos == st_q.fpos);
        ft_err   = (rx_bit == st_q.last_ft);
        err_win  = {st_q.errs[LOSS_WIN-2:0], ft_err};
        sig_next = {st_q.sig_hist[SIG_LEN-2:0], rx_bit};
        sig_hit  = !st_q.mlock && (sig_next == SIG_WORD);
        accept   = allow_mimic ? (run >= QUAL_V) : ((run == TOP_V) && solo);

        if (!st_q.tlock) begin
            if (accept) begin
                st_d.tlock    = 1'b1;
                st_d.mlock    = 1'b0;
                st_d.fpos     = pos;
                st_d.ft_next  = 1'b0;
                st_d.last_ft  = rx_bit;
                st_d.errs     = '0;
                st_d.sig_hist = '1;
                st_d.sf_idx   = '0;
            end
        end else if (at_fbit) begin
            st_d.ft_next = !st_q.ft_next;
            st_d.sf_idx  = (st_q.sf_idx == SF_LAST) ? '0 : st_q.sf_idx + 4'd1;
            if (st_q.ft_next) begin
                st_d.errs    = err_win;
                st_d.last_ft = !st_q.last_ft;
                if ($countones(err_win) >= LOSS_ERRS) begin
                    st_d.tlock = 1'b0;
                    st_d.mlock = 1'b0;
                    clr        = 1'b1;
                end
            end else begin
                st_d.sig_hist = sig_next;
                if (sig_hit) begin
                    st_d.mlock  = 1'b1;
                    st_d.sf_idx = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm_pulse    = at_fbit;
    assign sf_pulse     = at_fbit && st_q.mlock && (st_q.sf_idx == '0);
    assign sig_pulse    = at_fbit && st_q.mlock &&
                          (st_q.sf_idx == SF_SIX || st_q.sf_idx == SF_LAST);
    assign term_lock_n  = !st_q.tlock;
    assign multi_lock_n = !st_q.mlock;
endmodule

// File: rtl/t1sf_framer_chk.sv
module t1sf_framer_chk #(
    parameter int FRAME_BITS = 193
) (
    input logic clk,
    input logic rst_n,
    input logic frm_pulse,
    input logic sf_pulse,
    input logic sig_pulse,
    input logic term_lock_n,
    input logic multi_lock_n
);
    localparam int CW = $clog2(FRAME_BITS + 2);
    localparam logic [CW-1:0] SAT = CW'(FRAME_BITS + 1);
    localparam logic [CW-1:0] FB  = CW'(FRAME_BITS);

    // cycles elapsed since the last framing bit (pulse or lock sample)
    logic [CW-1:0] gap_q;
    logic          tl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            tl_q  <= 1'b1;
        end else begin
            tl_q <= term_lock_n;
            if (frm_pulse)                 gap_q <= CW'(1);
            else if (tl_q && !term_lock_n) gap_q <= CW'(2);
            else if (gap_q != SAT)         gap_q <= gap_q + CW'(1);
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (term_lock_n && multi_lock_n && !frm_pulse && !sf_pulse && !sig_pulse));

    assert_frame_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_pulse |-> (gap_q == FB));

    assert_pulse_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_pulse |-> !term_lock_n);

    assert_multi_under_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !multi_lock_n |-> !term_lock_n);

    assert_multi_after_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(multi_lock_n) |-> $past(!term_lock_n));

    assert_sf_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_pulse || sig_pulse) |-> (frm_pulse && !multi_lock_n));

    assert_sf_sig_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sf_pulse && sig_pulse));

    assert_release_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_lock_n) |-> multi_lock_n);
endmodule

bind t1sf_framer t1sf_framer_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (.*);

// File: tb/t1sf_framer_test.sv
module t1sf_framer_test;
    localparam int FB = 193;
    localparam int NEVER = 1 << 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic allow_mimic = 1'b0;
    logic frm_pulse, sf_pulse, sig_pulse, term_lock_n, multi_lock_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = !clk;

    t1sf_framer uut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .allow_mimic(allow_mimic),
        .frm_pulse(frm_pulse), .sf_pulse(sf_pulse), .sig_pulse(sig_pulse),
        .term_lock_n(term_lock_n), .multi_lock_n(multi_lock_n)
    );

    // scenario description
    int true_fp, mim_pos, mim_end, flip_a, flip_b, flip_c;
    int exp_fp, lock1, mlock1, loss_k, lock2, mlock2, term_tag, multi_tag;

    typedef struct packed {
        int   k;
        int   ttag;
        int   mtag;
        logic tl_n;
        logic ml_n;
        logic fp;
        logic sfp;
        logic sgp;
    } exp_t;

    exp_t sb[$];

    task automatic check(input logic got, input logic want, input int rq,
                         input string what, input int k);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL R%0d %s at bit %0d: actual=%b expected=%b", rq, what, k, got, want);
        end
    endtask

    function automatic logic gen_bit(input int gf, input int pos);
        int idx;
        logic [5:0] sseq;
        logic v;
        sseq = 6'b001110;
        idx = gf % 12;
        if (pos == true_fp) begin
            if (idx % 2 == 0) begin
                v = ((gf / 2) % 2 == 0);
                if (gf == flip_a || gf == flip_b || gf == flip_c) v = !v;
            end else begin
                v = sseq[5 - (idx - 1) / 2];
            end
            return v;
        end
        if (pos == mim_pos && gf % 2 == 0)
            return (gf < mim_end) ? ((gf / 2) % 2 == 0) : 1'b1;
        return (pos % 3 == 0);
    endfunction

    // monitor: pops one expectation per bit time and compares
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(term_lock_n,  e.tl_n, e.ttag, "term_lock_n", e.k);
                check(multi_lock_n, e.ml_n, e.mtag, "multi_lock_n", e.k);
                check(frm_pulse,    e.fp,   4,      "frm_pulse", e.k);     // R4
                check(sf_pulse,     e.sfp,  6,      "sf_pulse", e.k);      // R6
                check(sig_pulse,    e.sgp,  6,      "sig_pulse", e.k);     // R6
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_bit = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        // R1: idle outputs under reset
        check(term_lock_n, 1'b1, 1, "reset term_lock_n", -1);
        check(multi_lock_n, 1'b1, 1, "reset multi_lock_n", -1);
        check(frm_pulse, 1'b0, 1, "reset frm_pulse", -1);
        check(sf_pulse | sig_pulse, 1'b0, 1, "reset sf/sig", -1);
    endtask

    // driver: feeds the stream and pushes the expected outputs per bit
    task automatic drive(input int frames);
        exp_t e;
        for (int k = 0; k < frames * FB; k++) begin
            int gf, pos;
            logic ts, ms;
            @(negedge clk);
            rst_n = 1'b1;
            gf = k / FB;
            pos = k % FB;
            rx_bit = gen_bit(gf, pos);
            ts = (k > lock1 && k <= loss_k) || k > lock2;
            ms = (k > mlock1 && k <= loss_k) || k > mlock2;
            e.k = k;
            e.ttag = (k > loss_k) ? 8 : term_tag;   // R8 after release
            e.mtag = (k > loss_k) ? 8 : multi_tag;
            e.tl_n = !ts;
            e.ml_n = !ms;
            e.fp = ts && (pos == exp_fp);
            e.sfp = ms && e.fp && (gf % 12 == 0);
            e.sgp = ms && e.fp && (gf % 12 == 5 || gf % 12 == 11);
            sb.push_back(e);
        end
        @(negedge clk);
    endtask

    initial begin
        // A: strict mode, clean lock at position 50, superframe lock,
        //    one tolerated error, then a release and a relock (R3 R5 R6 R8)
        allow_mimic = 1'b0;
        true_fp = 50; mim_pos = -1; mim_end = 0;
        flip_a = 40; flip_b = 52; flip_c = 54;
        exp_fp = 50; term_tag = 3; multi_tag = 5;
        lock1 = 16 * FB + 50; mlock1 = 35 * FB + 50;
        loss_k = 54 * FB + 50;
        lock2 = 72 * FB + 50; mlock2 = 83 * FB + 50;
        do_reset();
        drive(90);

        // B: strict mode, second alternating position at 20 blocks lock
        //    until it breaks at frame 30 (R3), superframe lock follows (R5)
        true_fp = 50; mim_pos = 20; mim_end = 30;
        flip_a = -1; flip_b = -1; flip_c = -1;
        exp_fp = 50; term_tag = 3; multi_tag = 5;
        lock1 = 30 * FB + 50; mlock1 = 47 * FB + 50;
        loss_k = NEVER; lock2 = NEVER; mlock2 = NEVER;
        do_reset();
        drive(56);

        // C: permissive mode, earlier position 20 qualifies first (R2);
        //    its interleaved bits never carry the sequence, lock holds (R7)
        allow_mimic = 1'b1;
        mim_pos = 20; mim_end = NEVER;
        exp_fp = 20; term_tag = 2; multi_tag = 7;
        lock1 = 14 * FB + 20; mlock1 = NEVER;
        loss_k = NEVER; lock2 = NEVER; mlock2 = NEVER;
        do_reset();
        drive(60);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule